// File: doc/BRIEF.md
# Two-Wire Bus Slave Front End with Write-Busy Polling

This block is the serial front end of a register-based peripheral on a two-wire bus. SCL and SDA are brought into the system clock domain through a synchroniser, and START and STOP conditions are detected there. After a START, the first byte is compared with a fixed four-bit type code and with three pin-strapped address bits. When both match, the slave acknowledges the byte and takes either a write or a read transfer, as bit 0 of that byte selects. The block drives SDA only through an open-drain enable: a high enable pulls the line low.

In a write transfer, each byte that arrives is handed to the attached register block in a one-cycle strobe, and the slave acknowledges it. In a read transfer, the block asks the register block for a byte with a one-cycle fetch pulse, shifts the byte out with the most significant bit first, and then samples the host's acknowledge. The host's acknowledge makes the block fetch and send another byte. A not-acknowledge makes it let go of the line.

The register block marks a write as one that needs a nonvolatile commit. When that write transaction is closed by STOP, the block counts out a busy window of a set length. Inside the window a correct address gets no acknowledge. A host finds out that the commit is done by addressing the device again and again until it acknowledges.

Top module: `twi_poll_slave`

## Requirements
- R1: An address byte is accepted when its bits 7..4 are 4'b0101 and its bits 3..1 equal `strap_i[2:0]`, with bit 3 compared to `strap_i[2]`. The slave then holds `sda_oe` high for the whole ninth SCL clock of that byte.
- R2: An address byte that does not match gets no acknowledge. After it, the slave leaves `sda_oe` low, produces no `wr_valid` and no `rd_fetch`, and waits for the next START.
- R3: Bit 0 of an accepted address byte selects the direction: 1 for a read transfer, 0 for a write transfer.
- R4: In a write transfer, every following byte is assembled from SDA with the first bit as bit 7. It is presented on `wr_data` with a one-cycle `wr_valid` pulse, and it is acknowledged on its ninth clock.
- R5: In a read transfer, each byte comes from `tx_byte_i` in the cycle of a one-cycle `rd_fetch` pulse and is sent with bit 7 first. SDA is released for the ninth clock. If the host acknowledges, the next byte is fetched and sent. If the host does not acknowledge, the slave stops driving until the next START.
- R6: A START at any point abandons the current transfer and begins a new address byte. A STOP returns the slave to idle with SDA released.
- R7: If `nv_commit_i` is high in any cycle of a write transfer, the STOP that ends that transaction starts a busy window of `BUSY_CYCLES` clocks. Inside this window a matching address byte is not acknowledged, whatever its bit 0 is, so no data is accepted and none is fetched. After the window the address is acknowledged again.
- R8: A write transaction in which `nv_commit_i` was never high starts no busy window, and the next matching address is acknowledged at once.
- R9: `sda_oe` changes only while the synchronised SCL is low, or in the cycle in which a START or STOP is detected.
- R10: After reset, `sda_oe`, `wr_valid` and `rd_fetch` are low and the slave is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| strap_i | input | 3 | Pin-strapped device address bits |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| wr_valid | output | 1 | One-cycle strobe for a received write byte |
| wr_data | output | 8 | Received write byte |
| rd_fetch | output | 1 | One-cycle request for the next byte to send |
| tx_byte_i | input | 8 | Byte to send, valid in the `rd_fetch` cycle |
| nv_commit_i | input | 1 | Marks the current write as needing a nonvolatile commit |

## Verification
Some properties are checked on every cycle. The open-drain enable only moves while synchronised SCL is low or on a bus condition. No address acknowledge is given and no read byte is fetched while the busy window runs. Each received write byte is followed by an acknowledge drive, write strobes and fetch pulses never overlap, and a commit STOP raises the busy flag. Other behaviour can only be shown by the bench's bus scenarios. These cover the address-match table, byte order in both directions, the host's ACK and NACK in reads, abort by repeated START, and the timing of the busy window from the outside through polling.

// File: rtl/twi_pkg.sv
package twi_pkg;
    typedef enum logic [2:0] {
        LS_IDLE,
        LS_ADDR,
        LS_ADDR_ACK,
        LS_WR,
        LS_WR_ACK,
        LS_RD,
        LS_RD_ACK
    } link_state_e;

    typedef struct packed {
        link_state_e st;
        logic [7:0]  sh;
        logic [3:0]  cnt;
        logic        oe;
        logic        rw;
        logic        mack;
        logic        arm;
    } link_regs_t;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] now_o,
    output logic [WIDTH-1:0] prev_o
);
    logic [WIDTH-1:0] stage_q [STAGES+1];

    for (genvar s = 0; s <= STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= '1;
            end else if (s == 0) begin
                stage_q[s] <= raw_i;
            end else begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign now_o  = stage_q[STAGES-1];
    assign prev_o = stage_q[STAGES];
endmodule

// File: rtl/twi_busy_timer.sv
module twi_busy_timer #(
    parameter int BUSY_CYCLES = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    output logic busy_o
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);

    logic [CW-1:0] left_d, left_q;

    always_comb begin
        left_d = left_q;
        if (go_i) begin
            left_d = CW'(BUSY_CYCLES);
        end else if (left_q != '0) begin
            left_d = left_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) left_q <= '0;
        else        left_q <= left_d;
    end

    assign busy_o = (left_q != '0);

    // R7
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |=> busy_o);
endmodule

// File: rtl/twi_poll_slave.sv
module twi_poll_slave
    import twi_pkg::*;
#(
    parameter logic [3:0] TYPE_CODE   = 4'b0101,
    parameter int         SYNC_STAGES = 2,
    parameter int         BUSY_CYCLES = 1_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    output logic       sda_oe,
    output logic       wr_valid,
    output logic [7:0] wr_data,
    output logic       rd_fetch,
    input  logic [7:0] tx_byte_i,
    input  logic       nv_commit_i
);
    localparam logic [3:0] BYTE_BITS = 4'd8;

    logic [1:0] now_w, prev_w;
    logic       scl_s, sda_s, scl_p, sda_p;
    logic       scl_rise, scl_fall, bus_start, bus_stop;
    logic       busy, busy_go;
    logic       addr_hit;

    twi_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({scl_i, sda_i}),
        .now_o  (now_w),
        .prev_o (prev_w)
    );

    assign {scl_s, sda_s} = now_w;
    assign {scl_p, sda_p} = prev_w;
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign bus_start = scl_s & scl_p & sda_p & ~sda_s;
    assign bus_stop  = scl_s & scl_p & ~sda_p & sda_s;

    twi_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (busy_go),
        .busy_o (busy)
    );

    link_regs_t r_d, r_q;

    assign addr_hit = (r_q.sh[7:4] == TYPE_CODE) && (r_q.sh[3:1] == strap_i);

    always_comb begin
        r_d      = r_q;
        wr_valid = 1'b0;
        rd_fetch = 1'b0;
        busy_go  = 1'b0;

        if (nv_commit_i && (r_q.st == LS_WR || r_q.st == LS_WR_ACK)) begin
            r_d.arm = 1'b1;
        end

        unique case (r_q.st)
            LS_ADDR, LS_WR: begin
                if (scl_rise) begin
                    r_d.sh  = {r_q.sh[6:0], sda_s};
                    r_d.cnt = r_q.cnt + 1'b1;
                end else if (scl_fall && r_q.cnt == BYTE_BITS) begin
                    if (r_q.st == LS_WR) begin
                        wr_valid = 1'b1;
                        r_d.oe   = 1'b1;
                        r_d.st   = LS_WR_ACK;
                    end else if (addr_hit && !busy) begin
                        r_d.oe = 1'b1;
                        r_d.rw = r_q.sh[0];
                        r_d.st = LS_ADDR_ACK;
                    end else begin
                        r_d.st = LS_IDLE;
                    end
                end
            end
            LS_ADDR_ACK: begin
                if (scl_fall) begin
                    r_d.cnt = '0;
                    if (r_q.rw) begin
                        rd_fetch = 1'b1;
                        r_d.sh   = tx_byte_i;
                        r_d.oe   = ~tx_byte_i[7];
                        r_d.st   = LS_RD;
                    end else begin
                        r_d.oe = 1'b0;
                        r_d.st = LS_WR;
                    end
                end
            end
            LS_WR_ACK: begin
                if (scl_fall) begin
                    r_d.oe  = 1'b0;
                    r_d.cnt = '0;
                    r_d.st  = LS_WR;
                end
            end
            LS_RD: begin
                if (scl_rise) begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end else if (scl_fall) begin
                    if (r_q.cnt == BYTE_BITS) begin
                        r_d.oe = 1'b0;
                        r_d.st = LS_RD_ACK;
                    end else begin
                        r_d.sh = {r_q.sh[6:0], 1'b0};
                        r_d.oe = ~r_q.sh[6];
                    end
                end
            end
            LS_RD_ACK: begin
                if (scl_rise) begin
                    r_d.mack = ~sda_s;
                end else if (scl_fall) begin
                    if (r_q.mack) begin
                        rd_fetch = 1'b1;
                        r_d.sh   = tx_byte_i;
                        r_d.oe   = ~tx_byte_i[7];
                        r_d.cnt  = '0;
                        r_d.st   = LS_RD;
                    end else begin
                        r_d.st = LS_IDLE;
                    end
                end
            end
            default: ;
        endcase

        if (bus_start) begin
            r_d.st  = LS_ADDR;
            r_d.cnt = '0;
            r_d.oe  = 1'b0;
            r_d.arm = 1'b0;
            wr_valid = 1'b0;
            rd_fetch = 1'b0;
        end else if (bus_stop) begin
            r_d.st  = LS_IDLE;
            r_d.oe  = 1'b0;
            r_d.arm = 1'b0;
            busy_go = r_q.arm | r_d.arm;
            wr_valid = 1'b0;
            rd_fetch = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: LS_IDLE, sh: '0, cnt: '0, oe: 1'b0,
                     rw: 1'b0, mack: 1'b0, arm: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe  = r_q.oe;
    assign wr_data = r_q.sh;

    // R9
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> (!$past(scl_s) || $past(bus_start) || $past(bus_stop)));

    // R7
    addr_ack_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == LS_ADDR_ACK) |-> !busy);

    // R7
    fetch_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fetch |-> !busy);

    // R4
    wr_ack_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> sda_oe);

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_valid, rd_fetch}));
endmodule

// File: tb/twi_poll_slave_bench.sv
`timescale 1ns/1ps
module twi_poll_slave_bench;
    localparam int BUSY = 1000;
    localparam int H    = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] strap = 3'b101;
    logic       sda_oe, wr_valid, rd_fetch;
    logic [7:0] wr_data;
    logic [7:0] tx_byte = 8'h96;
    logic       sda_bus;

    int checks = 0;
    int errors = 0;
    int wr_count = 0;
    logic [7:0] wr_log [16];
    bit done = 0;

    always #2.5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    twi_poll_slave #(.BUSY_CYCLES(BUSY)) u_twi_poll_slave (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_bus),
        .strap_i     (strap),
        .sda_oe      (sda_oe),
        .wr_valid    (wr_valid),
        .wr_data     (wr_data),
        .rd_fetch    (rd_fetch),
        .tx_byte_i   (tx_byte),
        .nv_commit_i (wr_valid & wr_data[7])
    );

    // register-block model: fetched bytes advance by 0x11, writes are logged
    always @(posedge clk) begin
        if (rd_fetch) tx_byte <= tx_byte + 8'h11;
        if (wr_valid) begin
            wr_log[wr_count[3:0]] <= wr_data;
            wr_count <= wr_count + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(H);
        scl_m = 1'b1; wait_clk(H);
        sda_m = 1'b0; wait_clk(H);
        scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(H);
        scl_m = 1'b1; wait_clk(H);
        sda_m = 1'b1; wait_clk(H);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wait_clk(H);
        scl_m = 1'b1; wait_clk(H);
        scl_m = 1'b0;
    endtask

    // sends a byte, returns 1 if the slave held SDA low through the ninth clock
    task automatic send_byte(input logic [7:0] b, output bit acked);
        bit low_a, low_b;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; wait_clk(H);
        @(negedge clk); low_a = !sda_bus;
        scl_m = 1'b1; wait_clk(H - 1);
        @(negedge clk); low_b = !sda_bus;
        scl_m = 1'b0;
        acked = low_a & low_b;
    endtask

    task automatic recv_byte(input bit host_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; wait_clk(H);
            scl_m = 1'b1; wait_clk(H / 2);
            @(negedge clk); b[i] = sda_bus;
            wait_clk(H / 2);
            scl_m = 1'b0;
        end
        send_bit(!host_ack);
    endtask

    // address table: {address byte, expected acknowledge}, straps = 3'b101
    localparam logic [8:0] ADDR_VEC [7] = '{
        {8'h5A, 1'b1},   // match, write
        {8'h5B, 1'b1},   // match, read
        {8'h4A, 1'b0},   // type code wrong
        {8'h58, 1'b0},   // strap bit 1 wrong
        {8'h5E, 1'b0},   // strap bit 2 wrong
        {8'hDA, 1'b0},   // type MSB wrong
        {8'h52, 1'b0}    // strap bit 3 wrong
    };

    initial begin
        bit ack;
        logic [7:0] rb;
        logic [7:0] exp_tx;
        int wc0;
        exp_tx = 8'h96;

        wait_clk(4);
        // R10 reset state
        check(sda_oe == 1'b0 && wr_valid == 1'b0 && rd_fetch == 1'b0, "R10", sda_oe, 0);
        rst_n = 1'b1;
        wait_clk(4);
        check(sda_oe == 1'b0, "R10", sda_oe, 0);

        // R1 R2 R3: address matching table
        foreach (ADDR_VEC[i]) begin
            wc0 = wr_count;
            bus_start();
            send_byte(ADDR_VEC[i][8:1], ack);
            check(ack == ADDR_VEC[i][0], ADDR_VEC[i][0] ? "R1" : "R2", ack, ADDR_VEC[i][0]);
            if (ack && ADDR_VEC[i][1]) begin
                recv_byte(1'b0, rb);
                check(rb == exp_tx, "R3 read selected", rb, exp_tx);
                exp_tx = exp_tx + 8'h11;
            end else if (!ack) begin
                send_byte(8'h33, ack);
                check(!ack && wr_count == wc0, "R2 ignored data", wr_count, wc0);
            end
            bus_stop();
        end

        // R4 R8: multi-byte write without commit
        wc0 = wr_count;
        bus_start();
        send_byte(8'h5A, ack);
        send_byte(8'h12, ack);
        check(ack, "R4 ack byte1", ack, 1);
        send_byte(8'h6C, ack);
        check(ack, "R4 ack byte2", ack, 1);
        bus_stop();
        wait_clk(2);
        check(wr_count == wc0 + 2, "R4 count", wr_count, wc0 + 2);
        check(wr_log[wc0[3:0]] == 8'h12 && wr_log[wc0[3:0] + 4'd1] == 8'h6C, "R4 data",
              wr_log[wc0[3:0] + 4'd1], 8'h6C);
        bus_start();
        send_byte(8'h5A, ack);
        check(ack, "R8 no busy", ack, 1);
        bus_stop();

        // R5: read with ACK then NACK, then no drive
        bus_start();
        send_byte(8'h5B, ack);
        check(ack, "R5 addr", ack, 1);
        recv_byte(1'b1, rb);
        check(rb == exp_tx, "R5 byte1", rb, exp_tx);
        exp_tx = exp_tx + 8'h11;
        recv_byte(1'b0, rb);
        check(rb == exp_tx, "R5 byte2", rb, exp_tx);
        exp_tx = exp_tx + 8'h11;
        recv_byte(1'b0, rb);
        check(rb == 8'hFF, "R5 released after NACK", rb, 8'hFF);
        bus_stop();

        // R6: abort by repeated START mid-address
        bus_start();
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        bus_start();
        send_byte(8'h5A, ack);
        check(ack, "R6 restart", ack, 1);
        bus_stop();
        // R6: STOP in mid data byte returns to idle
        bus_start();
        send_byte(8'h5A, ack);
        send_bit(1'b1); send_bit(1'b0);
        bus_stop();
        check(sda_oe == 1'b0, "R6 stop idle", sda_oe, 0);

        // R7: commit write starts busy window
        bus_start();
        send_byte(8'h5A, ack);
        send_byte(8'h81, ack);
        check(ack, "R7 commit byte ack", ack, 1);
        bus_stop();
        wc0 = wr_count;
        bus_start();
        send_byte(8'h5A, ack);
        check(!ack, "R7 busy write poll", ack, 0);
        send_byte(8'h44, ack);
        check(wr_count == wc0, "R7 ignored write", wr_count, wc0);
        bus_stop();
        bus_start();
        send_byte(8'h5B, ack);
        check(!ack, "R7 busy read poll", ack, 0);
        bus_stop();
        wait_clk(BUSY);
        bus_start();
        send_byte(8'h5B, ack);
        check(ack, "R7 after busy", ack, 1);
        recv_byte(1'b0, rb);
        check(rb == exp_tx, "R7 read after busy", rb, exp_tx);
        bus_stop();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait_clk(150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule